// File: doc/BRIEF.md
# UART Receive Path with Sticky Error Flags

This block receives asynchronous serial frames on a single line and hands each byte to software through a one-entry receive buffer. A free-running oversampling enable (`os_tick`) sets the bit timing: one bit lasts `OVERSAMPLE` ticks. The line is resynchronized, a start bit is confirmed at its middle, and the data bits are gathered LSB first into a shift stage. An optional parity bit follows, with odd or even sense selectable. Then come one or two stop bits.

A finished frame goes straight to the buffer when the buffer is free. If the buffer still holds an unread byte, the frame stays in the shift stage and moves up on the next buffer read. Framing, parity and overrun problems raise sticky flags. Software clears a flag by writing a 1 in its bit position. A byte that carries an error is still delivered, and reception goes on without any intervention.

To recover from an overrun, software clears the overrun flag and reads the buffer twice, which drains both stored bytes. The two steps can be done in either order.

Top module: `uart_rx_errflags`

## Requirements
- R1: The receiver detects a frame when the line goes low and confirms the start bit when the line is still low `OVERSAMPLE/2` ticks later. It then samples 8 data bits, LSB first, each `OVERSAMPLE` ticks apart. If `parity_on` is 1, one parity bit follows. Then come one stop bit, or two when `stop2_sel` is 1. The configuration is latched when the start bit is confirmed.
- R2: A low pulse that is shorter than half a bit is not taken as a start bit, and no byte is produced from it.
- R3: When `parity_on` is 1, a parity mismatch sets `flag_parity` (write-1 bit 1). With `parity_odd`=1, the data bits plus the parity bit must hold an odd number of ones. With `parity_odd`=0, they must hold an even number. When `parity_on` is 0, no parity bit is expected and `flag_parity` is never set.
- R4: Parity and stop-bit errors are judged when a frame moves into the buffer. A frame that is waiting in the shift stage raises no flag.
- R5: A first stop bit sampled as 0 sets `flag_frame` (write-1 bit 0). When two stop bits are configured, the second one is never checked.
- R6: A byte with a parity or framing error is still loaded into the buffer. The next frame is received normally once the line has returned high.
- R7: `buf_full` rises when a byte is loaded. A read (`buf_rd`) clears `buf_full` unless a frame is waiting in the shift stage. In that case the waiting frame moves into the buffer on the same read, and `buf_full` stays 1.
- R8: If a start bit is confirmed while the buffer is full and a frame is waiting in the shift stage, `flag_overrun` (write-1 bit 2) is set. The new frame replaces the waiting one, so two reads return the old buffered byte and then the newest byte.
- R9: The error flags are sticky and reset to 0. A cycle with `flag_wr`=1 clears each flag whose `flag_wdata` bit is 1. A 0 bit leaves its flag unchanged.
- R10: When a flag's set condition and its write-1 clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, `OVERSAMPLE` per bit |
| rx_line | input | 1 | Serial input, idle high |
| parity_on | input | 1 | Expect and check a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2_sel | input | 1 | 1 = two stop bits |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| buf_data | output | DATA_BITS | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| flag_wr | input | 1 | Write strobe for the flag clear |
| flag_wdata | input | 3 | Write-1-to-clear mask: bit0 framing, bit1 parity, bit2 overrun |
| flag_frame | output | 1 | Sticky framing-error flag |
| flag_parity | output | 1 | Sticky parity-error flag |
| flag_overrun | output | 1 | Sticky overrun flag |

## Verification
The flag logic has one real coincidence: an error flag can be set by a transfer into the buffer in the same cycle that software writes a 1 to clear it. The bench provokes this directly. It parks a frame with bad parity in the shift stage behind a full buffer, then raises a buffer read and a parity-clear write on the same edge. That read performs the transfer that raises the flag. Afterwards the bench expects `flag_parity` to be 1 and the parked byte to be in the buffer. It also confirms that the flag stayed 0 while the frame was only waiting.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_STOP2,
      RX_REARM
   } rx_state_t;

   localparam int FLG_FRAME   = 0;
   localparam int FLG_PARITY  = 1;
   localparam int FLG_OVERRUN = 2;
   localparam int FLG_COUNT   = 3;

   // 1 when data plus parity bit do not match the selected sense
   function automatic logic parity_bad(input logic ones_odd, input logic par_bit,
                                       input logic want_odd);
      return (ones_odd ^ par_bit) != want_odd;
   endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("rx_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RESET_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RESET_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxs,
   input  logic                 cfg_par_en,
   input  logic                 cfg_par_odd,
   input  logic                 cfg_two_stop,
   output logic                 start_ok,
   output logic                 frame_done,
   output logic [DATA_BITS-1:0] fr_data,
   output logic                 fr_par_bit,
   output logic                 fr_par_chk,
   output logic                 fr_par_odd,
   output logic                 fr_stop_bad
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int BIT_W = $clog2(DATA_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

   rx_state_t           st;
   logic [CNT_W-1:0]    cnt;
   logic [BIT_W-1:0]    bitn;
   logic [DATA_BITS-1:0] shreg;
   logic                par_q, stop_bad_q;
   logic                en_q, odd_q, two_q;
   logic                at_end;

   assign at_end = tick && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         par_q      <= 1'b0;
         stop_bad_q <= 1'b0;
         en_q       <= 1'b0;
         odd_q      <= 1'b0;
         two_q      <= 1'b0;
         start_ok   <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         start_ok   <= 1'b0;
         frame_done <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (tick && !rxs) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == CNT_MID) begin
                     cnt <= '0;
                     if (!rxs) begin
                        start_ok <= 1'b1;
                        st       <= RX_DATA;
                        bitn     <= '0;
                        en_q     <= cfg_par_en;
                        odd_q    <= cfg_par_odd;
                        two_q    <= cfg_two_stop;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (at_end) begin
                  cnt   <= '0;
                  shreg <= {rxs, shreg[DATA_BITS-1:1]};
                  if (bitn == BIT_LAST) st <= en_q ? RX_PAR : RX_STOP;
                  else                  bitn <= bitn + 1'b1;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (at_end) begin
                  cnt   <= '0;
                  par_q <= rxs;
                  st    <= RX_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (at_end) begin
                  cnt        <= '0;
                  stop_bad_q <= !rxs;
                  frame_done <= 1'b1;
                  st         <= two_q ? RX_STOP2 : RX_REARM;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP2: begin
               // second stop bit is timed but not checked
               if (at_end) begin
                  cnt <= '0;
                  st  <= RX_REARM;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_REARM: begin
               if (rxs) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   assign fr_data     = shreg;
   assign fr_par_bit  = par_q;
   assign fr_par_chk  = en_q;
   assign fr_par_odd  = odd_q;
   assign fr_stop_bad = stop_bad_q;

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_ok,
   input  logic                 frame_done,
   input  logic [DATA_BITS-1:0] fr_data,
   input  logic                 fr_par_bit,
   input  logic                 fr_par_chk,
   input  logic                 fr_par_odd,
   input  logic                 fr_stop_bad,
   input  logic                 rd,
   output logic [DATA_BITS-1:0] buf_data,
   output logic                 buf_full,
   output logic                 hold_v,
   output logic [FLG_COUNT-1:0] set_vec
);

   logic [DATA_BITS-1:0] hold_data;
   logic                 hold_par_bit, hold_par_chk, hold_par_odd, hold_stop_bad;
   logic                 move_hold, load_direct;
   logic                 pe_direct, pe_hold;

   assign move_hold   = rd && buf_full && hold_v;
   assign load_direct = frame_done && (!buf_full || (rd && !hold_v));

   assign pe_direct = fr_par_chk &&
                      parity_bad(^fr_data, fr_par_bit, fr_par_odd);
   assign pe_hold   = hold_par_chk &&
                      parity_bad(^hold_data, hold_par_bit, hold_par_odd);

   always_comb begin
      set_vec              = '0;
      set_vec[FLG_FRAME]   = (load_direct && fr_stop_bad) ||
                             (move_hold && hold_stop_bad);
      set_vec[FLG_PARITY]  = (load_direct && pe_direct) ||
                             (move_hold && pe_hold);
      set_vec[FLG_OVERRUN] = start_ok && buf_full && hold_v && !move_hold;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_data      <= '0;
         buf_full      <= 1'b0;
         hold_v        <= 1'b0;
         hold_data     <= '0;
         hold_par_bit  <= 1'b0;
         hold_par_chk  <= 1'b0;
         hold_par_odd  <= 1'b0;
         hold_stop_bad <= 1'b0;
      end else begin
         if (rd && buf_full) begin
            if (hold_v) begin
               buf_data <= hold_data;
               hold_v   <= 1'b0;
            end else begin
               buf_full <= 1'b0;
            end
         end
         if (frame_done) begin
            if (load_direct) begin
               buf_data <= fr_data;
               buf_full <= 1'b1;
            end else begin
               hold_data     <= fr_data;
               hold_par_bit  <= fr_par_bit;
               hold_par_chk  <= fr_par_chk;
               hold_par_odd  <= fr_par_odd;
               hold_stop_bad <= fr_stop_bad;
               hold_v        <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flags
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_vec[i] | (flags[i] & ~(wr & wdata[i]));
         end
      end
   endgenerate

endmodule

// File: rtl/uart_rx_errflags.sv
module uart_rx_errflags
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 rx_line,
   input  logic                 parity_on,
   input  logic                 parity_odd,
   input  logic                 stop2_sel,
   input  logic                 buf_rd,
   output logic [DATA_BITS-1:0] buf_data,
   output logic                 buf_full,
   input  logic                 flag_wr,
   input  logic [2:0]           flag_wdata,
   output logic                 flag_frame,
   output logic                 flag_parity,
   output logic                 flag_overrun
);

   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
         $error("uart_rx_errflags: DATA_BITS out of range 5..9");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("uart_rx_errflags: OVERSAMPLE must be even and >= 4");
      end
      if (FLG_COUNT != 3) begin : g_bad_flags
         $error("uart_rx_errflags: flag port width mismatch");
      end
   endgenerate

   logic                 rxs;
   logic                 start_ok, frame_done;
   logic [DATA_BITS-1:0] fr_data;
   logic                 fr_par_bit, fr_par_chk, fr_par_odd, fr_stop_bad;
   logic                 hold_v;
   logic [FLG_COUNT-1:0] set_vec;
   logic [FLG_COUNT-1:0] flags;

   rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rxs)
   );

   rx_framer #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (os_tick),
      .rxs          (rxs),
      .cfg_par_en   (parity_on),
      .cfg_par_odd  (parity_odd),
      .cfg_two_stop (stop2_sel),
      .start_ok     (start_ok),
      .frame_done   (frame_done),
      .fr_data      (fr_data),
      .fr_par_bit   (fr_par_bit),
      .fr_par_chk   (fr_par_chk),
      .fr_par_odd   (fr_par_odd),
      .fr_stop_bad  (fr_stop_bad)
   );

   rx_buffer #(.DATA_BITS(DATA_BITS)) u_buffer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ok    (start_ok),
      .frame_done  (frame_done),
      .fr_data     (fr_data),
      .fr_par_bit  (fr_par_bit),
      .fr_par_chk  (fr_par_chk),
      .fr_par_odd  (fr_par_odd),
      .fr_stop_bad (fr_stop_bad),
      .rd          (buf_rd),
      .buf_data    (buf_data),
      .buf_full    (buf_full),
      .hold_v      (hold_v),
      .set_vec     (set_vec)
   );

   rx_flags #(.N(FLG_COUNT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .wr      (flag_wr),
      .wdata   (flag_wdata),
      .flags   (flags)
   );

   assign flag_frame   = flags[FLG_FRAME];
   assign flag_parity  = flags[FLG_PARITY];
   assign flag_overrun = flags[FLG_OVERRUN];

endmodule

// File: rtl/uart_rx_errflags_chk.sv
module uart_rx_errflags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       buf_rd,
   input logic       buf_full,
   input logic       flag_wr,
   input logic [2:0] flag_wdata,
   input logic       flag_frame,
   input logic       flag_parity,
   input logic       flag_overrun,
   input logic       start_ok,
   input logic       frame_done,
   input logic       hold_v,
   input logic [2:0] set_vec
);

   // R7
   load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && !buf_full |=> buf_full);

   // R7
   read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd && buf_full && !hold_v && !frame_done |=> !buf_full);

   // R7
   read_keeps_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd && buf_full && hold_v |=> buf_full);

   // R8
   overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok && buf_full && hold_v && !buf_rd |=> flag_overrun);

   // R4
   held_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_parity && frame_done && buf_full && !buf_rd |=> !flag_parity);

   // R9
   frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_frame && !(flag_wr && flag_wdata[0]) |=> flag_frame);

   // R9
   parity_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_parity && flag_wr && flag_wdata[1] && !set_vec[1] |=> !flag_parity);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[1] && flag_wr && flag_wdata[1] |=> flag_parity);

endmodule

bind uart_rx_errflags uart_rx_errflags_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .buf_rd       (buf_rd),
   .buf_full     (buf_full),
   .flag_wr      (flag_wr),
   .flag_wdata   (flag_wdata),
   .flag_frame   (flag_frame),
   .flag_parity  (flag_parity),
   .flag_overrun (flag_overrun),
   .start_ok     (start_ok),
   .frame_done   (frame_done),
   .hold_v       (hold_v),
   .set_vec      (set_vec)
);

// File: tb/tb_uart_rx_errflags.sv
module tb_uart_rx_errflags;

   localparam int BITCLK = 32;   // 16 ticks per bit, one tick every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic       parity_on = 1'b0, parity_odd = 1'b0, stop2_sel = 1'b0;
   logic       mon_rd = 1'b0, man_rd = 1'b0;
   logic       mon_wr = 1'b0, man_wr = 1'b0;
   logic [2:0] mon_wd = '0, man_wd = '0;
   logic       buf_rd, flag_wr;
   logic [2:0] flag_wdata;
   logic [7:0] buf_data;
   logic       buf_full, flag_frame, flag_parity, flag_overrun;

   int n_chk = 0, n_fail = 0;
   bit drain = 1'b0;
   bit done = 1'b0;
   logic [9:0] exp_q[$];   // {pe, fe, data}

   assign buf_rd     = mon_rd | man_rd;
   assign flag_wr    = mon_wr | man_wr;
   assign flag_wdata = mon_wd | man_wd;

   always #4 clk = ~clk;
   always @(negedge clk) os_tick <= ~os_tick;

   uart_rx_errflags dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
      .parity_on(parity_on), .parity_odd(parity_odd), .stop2_sel(stop2_sel),
      .buf_rd(buf_rd), .buf_data(buf_data), .buf_full(buf_full),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .flag_frame(flag_frame), .flag_parity(flag_parity),
      .flag_overrun(flag_overrun)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      rx_line = b;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par,
                             input logic stop1, input logic stop2);
      logic p;
      p = parity_odd ? ~^d : ^d;
      if (drain) exp_q.push_back({(parity_on && bad_par), ~stop1, d});
      put_bit(1'b0);
      for (int i = 0; i < 8; i++) put_bit(d[i]);
      if (parity_on) put_bit(p ^ bad_par);
      put_bit(stop1);
      if (stop2_sel) put_bit(stop2);
      put_bit(1'b1);
   endtask

   task automatic do_read();
      @(negedge clk); man_rd = 1'b1;
      @(negedge clk); man_rd = 1'b0;
   endtask

   task automatic do_clear(input logic [2:0] m);
      @(negedge clk); man_wr = 1'b1; man_wd = m;
      @(negedge clk); man_wr = 1'b0; man_wd = '0;
   endtask

   // monitor: pops the scoreboard as bytes appear
   initial begin
      forever begin
         @(negedge clk);
         if (drain && buf_full) begin
            if (exp_q.size() == 0) begin
               check("R6 unexpected byte", 1, 0);
            end else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               check("R1 data", buf_data, e[7:0]);
               check("R5 framing flag", flag_frame, e[8]);
               check("R3 parity flag", flag_parity, e[9]);
            end
            mon_rd = 1'b1; mon_wr = 1'b1; mon_wd = 3'b011;
            @(negedge clk);
            mon_rd = 1'b0; mon_wr = 1'b0; mon_wd = '0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // reset state
      check("R7 reset full", buf_full, 0);
      check("R9 reset flags", {flag_overrun, flag_parity, flag_frame}, 0);

      // R1 plain frames
      drain = 1'b1;
      send_frame(8'hA5, 0, 1, 1);
      send_frame(8'h3C, 0, 1, 1);
      send_frame(8'h00, 0, 1, 1);
      send_frame(8'hFF, 0, 1, 1);

      // R2 short glitch
      rx_line = 1'b0;
      repeat (8) @(negedge clk);
      rx_line = 1'b1;
      repeat (400) @(negedge clk);
      check("R2 glitch no byte", buf_full, 0);
      check("R2 queue drained", exp_q.size(), 0);

      // R3 parity even / odd, good and bad
      parity_on = 1'b1; parity_odd = 1'b0;
      send_frame(8'h5A, 0, 1, 1);
      send_frame(8'h5B, 1, 1, 1);
      parity_odd = 1'b1;
      send_frame(8'h13, 0, 1, 1);
      send_frame(8'h17, 1, 1, 1);
      parity_on = 1'b0;

      // R5 R6 framing error, then normal frame
      send_frame(8'h77, 0, 0, 1);
      send_frame(8'h21, 0, 1, 1);

      // R5 second stop bit ignored
      stop2_sel = 1'b1;
      send_frame(8'h81, 0, 1, 0);
      send_frame(8'h42, 0, 1, 1);
      stop2_sel = 1'b0;
      repeat (100) @(negedge clk);
      check("R6 all bytes seen", exp_q.size(), 0);
      drain = 1'b0;
      repeat (4) @(negedge clk);

      // R7 R8 overrun sequence
      send_frame(8'h11, 0, 1, 1);
      check("R7 full after load", buf_full, 1);
      send_frame(8'h22, 0, 1, 1);
      check("R7 older byte kept", buf_data, 8'h11);
      check("R8 no overrun yet", flag_overrun, 0);
      send_frame(8'h33, 0, 1, 1);
      check("R8 overrun set", flag_overrun, 1);
      do_clear(3'b011);
      check("R9 zero bit no effect", flag_overrun, 1);
      check("R8 first read data", buf_data, 8'h11);
      do_read();
      check("R8 newest byte moved up", buf_data, 8'h33);
      check("R7 still full", buf_full, 1);
      do_read();
      check("R7 empty after second read", buf_full, 0);
      do_clear(3'b100);
      check("R9 overrun cleared", flag_overrun, 0);

      // R4 R10 set and clear in the same cycle
      parity_on = 1'b1; parity_odd = 1'b0;
      send_frame(8'h0F, 0, 1, 1);
      send_frame(8'h0E, 1, 1, 1);
      check("R4 held frame no flag", flag_parity, 0);
      @(negedge clk);
      man_rd = 1'b1; man_wr = 1'b1; man_wd = 3'b010;
      @(negedge clk);
      man_rd = 1'b0; man_wr = 1'b0; man_wd = '0;
      check("R10 set wins", flag_parity, 1);
      check("R6 errored byte delivered", buf_data, 8'h0E);
      do_read();
      do_clear(3'b010);
      check("R9 parity cleared", flag_parity, 0);
      check("R7 empty at end", buf_full, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule